// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the processor-facing register set of a four-channel DMA controller. A byte-wide port bus (4-bit port offset, separate read and write strobes, 8-bit data) reaches each channel's 16-bit address and count registers. Each 16-bit register is accessed one byte at a time, and a single byte pointer shared by all channels selects which byte. The same bus carries the command, status, mode and mask controls. A second strobe reaches the per-channel page and high-page bytes. These bytes extend the current address to a full physical address.

The block performs no transfers. It presents each channel's decoded state to a separate transfer engine: the full current address, the current count, the mode byte, the mask bits, the software request bits and the command byte. The engine reports a terminal count through a set strobe per channel. The status port shows these terminal counts next to the request bits.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, status reads 0x00, the mask port (offset 0xF) reads 0x0F, command and all mode bytes are 0, and the first channel-register access uses the low byte.
- R2: Each read or write at offsets 0x0 to 0x7 toggles one byte pointer shared by all channels. The access uses the low byte when the pointer is 0 and the high byte when it is 1. A write to offset 0xC sets the pointer to 0 (low byte).
- R3: At offsets 0x0 to 0x7, bits [2:1] give the channel and bit 0 picks address (0) or count (1). A write of the high byte loads that base register and copies the whole new base value into the matching current register. A write of the low byte changes only the base.
- R4: A count read returns the byte of (base count minus current count), modulo 2^16, that the pointer selects.
- R5: An address read returns the byte of (current address plus current count), modulo 2^16, that the pointer selects. When mode bit 5 is 1 the count is subtracted instead.
- R6: A write to offset 0xB stores the whole data byte as the mode of the channel in data[1:0]. Mode bit 5 selects address decrement.
- R7: A write to offset 0x9 sets the request bit of the channel in data[1:0] to data[2]. Request bits appear at status[7:4] and terminal-count bits at status[3:0], with bit index equal to the channel.
- R8: A write to offset 0xA sets the mask bit of the channel in data[1:0] to data[2]. The other mask bits keep their values.
- R9: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads the mask bits from data[3:0], and a read there returns {4'b0, mask}.
- R10: A write to offset 0x8 loads the command byte. A read at offset 0x8 returns the status byte.
- R11: A pulse on tc_set[n] sets status bit n. A status read returns the bits as they stood, then clears status[3:0]. If a set pulse arrives in the same cycle as a status read, the set wins.
- R12: A write to offset 0xD clears command, status and the byte pointer and sets all mask bits. Channel, mode and page registers keep their values.
- R13: Page-port offsets 1, 2, 3 and 7 select channels 2, 3, 1 and 0. pg_high picks the high-page byte (7 bits are kept) over the page byte. The other offsets change nothing and read 0. Each channel's engine address is {high_page, page, current_address}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the main port bus |
| rd_en | input | 1 | Read strobe for the main port bus |
| port_ofs | input | 4 | Main port offset |
| wdata | input | 8 | Write data for both buses |
| rdata | output | 8 | Read data at port_ofs |
| pg_wr | input | 1 | Page-port write strobe |
| pg_high | input | 1 | Selects the high-page byte instead of the page byte |
| pg_ofs | input | 3 | Page-port offset |
| pg_rdata | output | 8 | Page byte at pg_ofs |
| tc_set | input | 4 | Terminal-count set pulses, one per channel |
| eng_addr | output | 124 | Full current address per channel, 31 bits each, channel 0 lowest |
| eng_count | output | 64 | Current count per channel, 16 bits each |
| eng_mode | output | 32 | Mode byte per channel |
| eng_mask | output | 4 | Mask bit per channel |
| eng_req | output | 4 | Software request bit per channel |
| eng_command | output | 8 | Command byte |

## Verification
Both read paths (rdata and pg_rdata) are combinational. They show the state held before the clock edge that ends the strobe. Writes, pointer toggles and status clears take effect at that edge and appear on the engine outputs and on later reads one cycle after the strobe. The bench drives each strobe from one falling edge to the next. It samples read data one time unit after the drive, while the strobe is still high. It samples engine outputs after the strobe has dropped. A byte-level model in the bench, including its own pointer, predicts every value one step at a time.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W = $clog2(NUM_CH);
    localparam int BYTE_W = 8;
    localparam int REG_W = 2 * BYTE_W;
    localparam int PAGE_W = 8;
    localparam int MODE_DEC_BIT = 5;
    localparam int SEL_REQ_BIT = 2;

    typedef enum logic [3:0] {
        OFS_STAT_CMD = 4'h8,
        OFS_SWREQ    = 4'h9,
        OFS_MASK1    = 4'hA,
        OFS_MODE     = 4'hB,
        OFS_PTR_CLR  = 4'hC,
        OFS_MRESET   = 4'hD,
        OFS_MASK_CLR = 4'hE,
        OFS_MASK_ALL = 4'hF
    } ctl_ofs_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } page_sel_t;

    function automatic page_sel_t page_decode(input logic [2:0] ofs);
        page_sel_t s;
        s = '0;
        case (ofs)
            3'd1: s = '{hit: 1'b1, ch: CH_W'(2)};
            3'd2: s = '{hit: 1'b1, ch: CH_W'(3)};
            3'd3: s = '{hit: 1'b1, ch: CH_W'(1)};
            3'd7: s = '{hit: 1'b1, ch: CH_W'(0)};
            default: s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        port_ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] tc_set,
    output logic              ptr_hi,
    output logic [BYTE_W-1:0] ctl_rdata,
    output logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] req,
    output logic [BYTE_W-1:0] command
);
    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [NUM_CH-1:0] req;
        logic [NUM_CH-1:0] tc;
        logic [NUM_CH-1:0] mask;
        logic              ptr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic chan_acc;
    logic [CH_W-1:0] sel_ch;

    assign chan_acc = (wr_en || rd_en) && !port_ofs[3];
    assign sel_ch   = wdata[CH_W-1:0];

    always_comb begin
        ctl_d = ctl_q;
        if (chan_acc) ctl_d.ptr = ~ctl_q.ptr;
        if (wr_en) begin
            case (port_ofs)
                OFS_STAT_CMD: ctl_d.cmd = wdata;
                OFS_SWREQ:    ctl_d.req[sel_ch] = wdata[SEL_REQ_BIT];
                OFS_MASK1:    ctl_d.mask[sel_ch] = wdata[SEL_REQ_BIT];
                OFS_PTR_CLR:  ctl_d.ptr = 1'b0;
                OFS_MRESET: begin
                    ctl_d.cmd  = '0;
                    ctl_d.req  = '0;
                    ctl_d.tc   = '0;
                    ctl_d.ptr  = 1'b0;
                    ctl_d.mask = '1;
                end
                OFS_MASK_CLR: ctl_d.mask = '0;
                OFS_MASK_ALL: ctl_d.mask = wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        if (rd_en && port_ofs == OFS_STAT_CMD) ctl_d.tc = '0;
        ctl_d.tc = ctl_d.tc | tc_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (port_ofs)
            OFS_STAT_CMD: ctl_rdata = {ctl_q.req, ctl_q.tc};
            OFS_MASK_ALL: ctl_rdata = BYTE_W'(ctl_q.mask);
            default:      ctl_rdata = '0;
        endcase
    end

    assign ptr_hi  = ctl_q.ptr;
    assign mask    = ctl_q.mask;
    assign req     = ctl_q.req;
    assign command = ctl_q.cmd;

    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past((wr_en || rd_en) && !port_ofs[3]) |-> (ctl_q.ptr != $past(ctl_q.ptr)));

    assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_PTR_CLR) |-> !ctl_q.ptr);

    assert_req_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_SWREQ) |-> (ctl_q.req[$past(sel_ch)] == $past(wdata[SEL_REQ_BIT])));

    assert_tc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && port_ofs == OFS_STAT_CMD && tc_set == '0) |-> (ctl_q.tc == '0));

    assert_tc_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tc_set != '0) |-> ((ctl_q.tc & $past(tc_set)) == $past(tc_set)));

    assert_master_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_MRESET && tc_set == '0)
        |-> (ctl_q.mask == '1 && ctl_q.req == '0 && ctl_q.tc == '0 && ctl_q.cmd == '0 && !ctl_q.ptr));
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int HPAGE_W = 7
)(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_sel,
    input  logic                              ptr_hi,
    input  logic [BYTE_W-1:0]                 wdata,
    input  logic                              mode_wr,
    input  logic                              pg_wr,
    input  logic                              pg_high,
    output logic [BYTE_W-1:0]                 reg_rdata,
    output logic [BYTE_W-1:0]                 pg_rdata,
    output logic [HPAGE_W+PAGE_W+REG_W-1:0]   xfer_addr,
    output logic [REG_W-1:0]                  xfer_count,
    output logic [BYTE_W-1:0]                 mode
);
    typedef struct packed {
        logic [REG_W-1:0]   base_addr;
        logic [REG_W-1:0]   base_cnt;
        logic [REG_W-1:0]   cur_addr;
        logic [REG_W-1:0]   cur_cnt;
        logic [BYTE_W-1:0]  mode;
        logic [PAGE_W-1:0]  page;
        logic [HPAGE_W-1:0] hpage;
    } chan_t;

    chan_t ch_q, ch_d;
    logic [REG_W-1:0] cnt_view, addr_view, view;

    always_comb begin
        ch_d = ch_q;
        if (reg_wr) begin
            if (!reg_sel) begin
                if (ptr_hi) begin
                    ch_d.base_addr[REG_W-1:BYTE_W] = wdata;
                    ch_d.cur_addr = {wdata, ch_q.base_addr[BYTE_W-1:0]};
                end else begin
                    ch_d.base_addr[BYTE_W-1:0] = wdata;
                end
            end else begin
                if (ptr_hi) begin
                    ch_d.base_cnt[REG_W-1:BYTE_W] = wdata;
                    ch_d.cur_cnt = {wdata, ch_q.base_cnt[BYTE_W-1:0]};
                end else begin
                    ch_d.base_cnt[BYTE_W-1:0] = wdata;
                end
            end
        end
        if (mode_wr) ch_d.mode = wdata;
        if (pg_wr) begin
            if (pg_high) ch_d.hpage = wdata[HPAGE_W-1:0];
            else         ch_d.page  = wdata[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    always_comb begin
        cnt_view  = ch_q.base_cnt - ch_q.cur_cnt;
        addr_view = ch_q.mode[MODE_DEC_BIT] ? (ch_q.cur_addr - ch_q.cur_cnt)
                                            : (ch_q.cur_addr + ch_q.cur_cnt);
        view      = reg_sel ? cnt_view : addr_view;
        reg_rdata = ptr_hi ? view[REG_W-1:BYTE_W] : view[BYTE_W-1:0];
        pg_rdata  = pg_high ? BYTE_W'(ch_q.hpage) : BYTE_W'(ch_q.page);
    end

    assign xfer_addr  = {ch_q.hpage, ch_q.page, ch_q.cur_addr};
    assign xfer_count = ch_q.cur_cnt;
    assign mode       = ch_q.mode;

    assert_addr_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && ptr_hi && !reg_sel) |-> (ch_q.cur_addr == ch_q.base_addr));

    assert_cnt_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && ptr_hi && reg_sel) |-> (ch_q.cur_cnt == ch_q.base_cnt));

    assert_low_keeps_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && !ptr_hi) |-> ($stable(ch_q.cur_addr) && $stable(ch_q.cur_cnt)));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int HPAGE_W = 7
)(
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic                                     rd_en,
    input  logic [3:0]                               port_ofs,
    input  logic [7:0]                               wdata,
    output logic [7:0]                               rdata,
    input  logic                                     pg_wr,
    input  logic                                     pg_high,
    input  logic [2:0]                               pg_ofs,
    output logic [7:0]                               pg_rdata,
    input  logic [3:0]                               tc_set,
    output logic [4*(HPAGE_W+PAGE_W+REG_W)-1:0]      eng_addr,
    output logic [4*REG_W-1:0]                       eng_count,
    output logic [4*BYTE_W-1:0]                      eng_mode,
    output logic [3:0]                               eng_mask,
    output logic [3:0]                               eng_req,
    output logic [7:0]                               eng_command
);
    localparam int AW = HPAGE_W + PAGE_W + REG_W;

    logic              ptr_hi;
    logic [BYTE_W-1:0] ctl_rdata;
    logic [BYTE_W-1:0] ch_rd [NUM_CH];
    logic [BYTE_W-1:0] ch_pg [NUM_CH];
    page_sel_t         pg_sel;

    assign pg_sel = page_decode(pg_ofs);

    dmac_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .port_ofs  (port_ofs),
        .wdata     (wdata),
        .tc_set    (tc_set),
        .ptr_hi    (ptr_hi),
        .ctl_rdata (ctl_rdata),
        .mask      (eng_mask),
        .req       (eng_req),
        .command   (eng_command)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic reg_wr_g, mode_wr_g, pg_wr_g;
        assign reg_wr_g  = wr_en && !port_ofs[3] && (port_ofs[2:1] == CH_W'(g));
        assign mode_wr_g = wr_en && (port_ofs == OFS_MODE) && (wdata[CH_W-1:0] == CH_W'(g));
        assign pg_wr_g   = pg_wr && pg_sel.hit && (pg_sel.ch == CH_W'(g));

        dmac_chan #(.HPAGE_W(HPAGE_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .reg_wr     (reg_wr_g),
            .reg_sel    (port_ofs[0]),
            .ptr_hi     (ptr_hi),
            .wdata      (wdata),
            .mode_wr    (mode_wr_g),
            .pg_wr      (pg_wr_g),
            .pg_high    (pg_high),
            .reg_rdata  (ch_rd[g]),
            .pg_rdata   (ch_pg[g]),
            .xfer_addr  (eng_addr[g*AW +: AW]),
            .xfer_count (eng_count[g*REG_W +: REG_W]),
            .mode       (eng_mode[g*BYTE_W +: BYTE_W])
        );
    end

    assign rdata    = port_ofs[3] ? ctl_rdata : ch_rd[port_ofs[2:1]];
    assign pg_rdata = pg_sel.hit ? ch_pg[pg_sel.ch] : '0;

    assert_mask_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_MASK1)
        |-> (eng_mask[$past(wdata[1:0])] == $past(wdata[2])));

    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_MASK_CLR) |-> (eng_mask == 4'h0));

    assert_cmd_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && port_ofs == OFS_STAT_CMD) |-> (eng_command == $past(wdata)));
endmodule

// File: tb/dmac_regfile_bench.sv
module dmac_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, pg_wr = 1'b0, pg_high = 1'b0;
    logic [3:0] port_ofs = '0;
    logic [7:0] wdata = '0;
    logic [2:0] pg_ofs = '0;
    logic [3:0] tc_set = '0;
    logic [7:0] rdata, pg_rdata;
    logic [4*AW-1:0] eng_addr;
    logic [63:0] eng_count;
    logic [31:0] eng_mode;
    logic [3:0] eng_mask, eng_req;
    logic [7:0] eng_command;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_baddr [4], m_bcnt [4], m_caddr [4], m_ccnt [4];
    logic [7:0]  m_mode [4], m_pg [4];
    logic [6:0]  m_hp [4];
    logic [3:0]  m_mask, m_req, m_tc;
    logic [7:0]  m_cmd;
    logic        m_ptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_regfile u_dmac_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .port_ofs(port_ofs), .wdata(wdata), .rdata(rdata),
        .pg_wr(pg_wr), .pg_high(pg_high), .pg_ofs(pg_ofs), .pg_rdata(pg_rdata),
        .tc_set(tc_set), .eng_addr(eng_addr), .eng_count(eng_count),
        .eng_mode(eng_mode), .eng_mask(eng_mask), .eng_req(eng_req),
        .eng_command(eng_command)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic io_wr(input logic [3:0] o, input logic [7:0] d);
        @(negedge clk);
        port_ofs = o; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic io_rd(input logic [3:0] o, output logic [7:0] got);
        @(negedge clk);
        port_ofs = o; rd_en = 1'b1;
        #1 got = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pg_write(input logic [2:0] o, input logic h, input logic [7:0] d);
        @(negedge clk);
        pg_ofs = o; pg_high = h; wdata = d; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic chwr(input int ch, input logic sel, input logic [7:0] d);
        io_wr({ch[1:0], sel}, d);
        if (!sel) begin
            if (m_ptr) begin m_baddr[ch][15:8] = d; m_caddr[ch] = m_baddr[ch]; end
            else m_baddr[ch][7:0] = d;
        end else begin
            if (m_ptr) begin m_bcnt[ch][15:8] = d; m_ccnt[ch] = m_bcnt[ch]; end
            else m_bcnt[ch][7:0] = d;
        end
        m_ptr = ~m_ptr;
    endtask

    task automatic chrd(input int ch, input logic sel, input string tag);
        logic [15:0] view;
        logic [7:0] got;
        if (sel) view = m_bcnt[ch] - m_ccnt[ch];
        else if (m_mode[ch][5]) view = m_caddr[ch] - m_ccnt[ch];
        else view = m_caddr[ch] + m_ccnt[ch];
        io_rd({ch[1:0], sel}, got);
        chk(tag, got, m_ptr ? view[15:8] : view[7:0]);
        m_ptr = ~m_ptr;
    endtask

    task automatic chk_eng(input int ch, input string tag);
        #1;
        chk(tag, eng_addr[ch*AW +: AW], {m_hp[ch], m_pg[ch], m_caddr[ch]});
        chk(tag, eng_count[ch*16 +: 16], m_ccnt[ch]);
    endtask

    task automatic chk_status(input string tag);
        logic [7:0] got;
        io_rd(4'h8, got);
        chk(tag, got, {m_req, m_tc});
        m_tc = '0;
    endtask

    function automatic int page_chan(input int o);
        case (o)
            1: return 2;
            2: return 3;
            3: return 1;
            7: return 0;
            default: return -1;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        for (int c = 0; c < 4; c++) begin
            m_baddr[c] = '0; m_bcnt[c] = '0; m_caddr[c] = '0; m_ccnt[c] = '0;
            m_mode[c] = '0; m_pg[c] = '0; m_hp[c] = '0;
        end
        m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_status("R1");
        io_rd(4'hF, got); chk("R1", got, 8'h0F);
        chk("R1", eng_mode, 32'h0);
        chk("R1", eng_command, 8'h00);
        chk("R1", eng_mask, 4'hF);
        chwr(0, 1'b0, 8'h21);
        chwr(0, 1'b0, 8'h43);
        chk_eng(0, "R1");

        // R3, R4, R5, R6 sweep over channels and value patterns
        for (int ch = 0; ch < 4; ch++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] a, c;
                logic [7:0] md;
                a = 16'(16'h1357 * (ch + 1) + k * 16'h2F1D);
                c = 16'(16'h0A05 * (k + 1) + ch * 16'h1111);
                chwr(ch, 1'b0, a[7:0]); chwr(ch, 1'b0, a[15:8]);
                chwr(ch, 1'b1, c[7:0]); chwr(ch, 1'b1, c[15:8]);
                chk_eng(ch, "R3");
                chrd(ch, 1'b1, "R4"); chrd(ch, 1'b1, "R4");
                chrd(ch, 1'b0, "R5"); chrd(ch, 1'b0, "R5");
                md = {2'(k), 1'b1, 1'b0, 2'b01, 2'(ch)};
                io_wr(4'hB, md); m_mode[ch] = md;
                #1 chk("R6", eng_mode[ch*8 +: 8], md);
                chrd(ch, 1'b0, "R5"); chrd(ch, 1'b0, "R5");
                md = {2'(k), 1'b0, 1'b1, 2'b10, 2'(ch)};
                io_wr(4'hB, md); m_mode[ch] = md;
                #1 chk("R6", eng_mode, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
                // low byte only, then pointer clear: current keeps old value
                chwr(ch, 1'b1, 8'(8'h5A + k));
                chk_eng(ch, "R3");
                io_wr(4'hC, 8'h00); m_ptr = 1'b0;
                chrd(ch, 1'b1, "R2"); chrd(ch, 1'b1, "R4");
            end
        end

        // R2 pointer shared across channels
        chwr(0, 1'b0, 8'hAA);
        chwr(1, 1'b0, 8'h55);
        chk_eng(1, "R2");
        chk_eng(0, "R2");
        chrd(2, 1'b1, "R2");
        chwr(3, 1'b1, 8'h99);
        chk_eng(3, "R2");

        // R7 software requests
        for (int ch = 0; ch < 4; ch++) begin
            io_wr(4'h9, {5'b0, 1'b1, 2'(ch)}); m_req[ch] = 1'b1;
            #1 chk("R7", eng_req, m_req);
        end
        io_wr(4'h9, 8'h01); m_req[1] = 1'b0;
        io_wr(4'h9, 8'hFB); m_req[3] = 1'b0;
        #1 chk("R7", eng_req, m_req);
        chk_status("R7");

        // R8 single mask sweep
        io_wr(4'hE, 8'h00); m_mask = '0;
        #1 chk("R9", eng_mask, 4'h0);
        for (int d = 0; d < 8; d++) begin
            io_wr(4'hA, 8'(d)); m_mask[d % 4] = (d >= 4);
            #1 chk("R8", eng_mask, m_mask);
        end
        io_wr(4'hA, 8'h01); m_mask[1] = 1'b0;
        #1 chk("R8", eng_mask, m_mask);

        // R9 all-mask write and readback
        for (int v = 0; v < 16; v++) begin
            io_wr(4'hF, {4'hA, 4'(v)}); m_mask = 4'(v);
            io_rd(4'hF, got); chk("R9", got, {4'h0, m_mask});
            #1 chk("R9", eng_mask, m_mask);
        end
        io_wr(4'hE, 8'hFF); m_mask = '0;
        io_rd(4'hF, got); chk("R9", got, 8'h00);

        // R10 command register and status read
        for (int v = 0; v < 4; v++) begin
            m_cmd = 8'(8'h3C * (v + 1));
            io_wr(4'h8, m_cmd);
            #1 chk("R10", eng_command, m_cmd);
            chk_status("R10");
        end

        // R11 terminal count set and read-to-clear
        @(negedge clk); tc_set = 4'b0101;
        @(negedge clk); tc_set = 4'b0000; m_tc = 4'b0101;
        chk_status("R11");
        chk_status("R11");
        @(negedge clk);
        port_ofs = 4'h8; rd_en = 1'b1; tc_set = 4'b1010;
        #1 chk("R11", rdata, {m_req, 4'b0000});
        @(negedge clk);
        rd_en = 1'b0; tc_set = 4'b0000; m_tc = 4'b1010;
        chk_status("R11");

        // R12 master reset
        io_wr(4'h9, 8'h06); m_req[2] = 1'b1;
        io_wr(4'hA, 8'h02); m_mask[2] = 1'b0;
        @(negedge clk); tc_set = 4'b0011;
        @(negedge clk); tc_set = 4'b0000;
        chwr(2, 1'b0, 8'h77);
        io_wr(4'hD, 8'h00);
        m_cmd = '0; m_req = '0; m_tc = '0; m_ptr = 1'b0; m_mask = 4'hF;
        #1 chk("R12", eng_mask, 4'hF);
        chk("R12", eng_command, 8'h00);
        chk("R12", eng_mode, {m_mode[3], m_mode[2], m_mode[1], m_mode[0]});
        chk_status("R12");
        chrd(2, 1'b0, "R12");
        chk_eng(2, "R12");

        // R13 page and high-page ports
        for (int o = 0; o < 8; o++) begin
            for (int h = 0; h < 2; h++) begin
                logic [7:0] v;
                int pc;
                v = 8'(8'h91 + o * 8'h13 + h * 8'h40);
                pc = page_chan(o);
                pg_write(3'(o), h[0], v);
                if (pc >= 0) begin
                    if (h == 1) m_hp[pc] = v[6:0];
                    else m_pg[pc] = v;
                end
                @(negedge clk);
                pg_ofs = 3'(o); pg_high = h[0];
                #1;
                if (pc < 0) chk("R13", pg_rdata, 8'h00);
                else chk("R13", pg_rdata, (h == 1) ? {1'b0, m_hp[pc]} : m_pg[pc]);
                for (int c = 0; c < 4; c++)
                    chk("R13", eng_addr[c*AW +: AW], {m_hp[c], m_pg[c], m_caddr[c]});
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule